// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host read and write an external asynchronous static RAM. The RAM is 16 bits wide with two byte lanes, and its default depth is 256K words. The host presents an address, write data, a read/write flag and one strobe for each byte lane. The host holds the request until the controller returns an acknowledge, which comes with the read data on reads.

On the memory side the controller drives the address, an active-low chip select, write enable and output enable, and one active-low enable for each byte lane. It also drives a tri-state data bus together with its direction control.

Every access holds chip select low for a number of wait states. That number is computed from the clock period and the memory access time. A write commits when write enable rises, and the address and data stay unchanged through that edge. Accesses are separated by idle cycles, and the controller drives the data bus only when the memory outputs are certainly off.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip select, write enable and output enable are high, the bus drive control is low and acknowledge is low.
- R2: Every memory access holds chip select low for exactly WAIT = ceil(T_ACC_PS / CLK_PS) consecutive cycles (6 at a 10 ns clock and 55 ns access time).
- R3: A write holds write enable low while chip select is low. Host strobe bit 0 maps to the low-lane enable (data bits 7:0) and bit 1 maps to the high-lane enable (bits 15:8). Only the enabled lanes of the addressed word change, and the address and drive data are stable on the cycle in which write enable rises.
- R4: A read holds output enable low and write enable high. The bus is captured on the last wait-state cycle. Lanes whose strobe is 0 return zero in the read data.
- R5: Each accepted request produces an acknowledge that lasts exactly one cycle.
- R6: A request with both strobes at 0 is acknowledged without chip select going low, and memory contents are unchanged.
- R7: After chip select rises it stays high for at least one cycle before the next access.
- R8: The bus drive control is never high while output enable is low, it is raised only after output enable was high on the previous cycle, and controller and memory never drive the bus at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane strobes, bit 0 = bits 7:0 |
| resp_ack | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read data, valid with acknowledge |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | High-lane enable, active low |
| mem_lb_n | output | 1 | Low-lane enable, active low |
| mem_dq | inout | 16 | Bidirectional data bus |
| mem_dq_oe | output | 1 | High while the controller drives mem_dq |

## Verification
The bench builds the controller with ADDR_W = 6 and the default 10 ns clock and 55 ns access time. The 64-word space can therefore be swept completely, and the wait count resolves to 6 cycles. Every address is written in full, then overwritten in one lane chosen by address parity, then read back in full and through each single lane. The results are compared with a lane-split behavioural memory. A monitor measures the chip-select width of every access and flags any cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_GAP  = 2'd2
  } ctrl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int WAIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = $clog2(WAIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == CW'(WAIT - 1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < CW'(WAIT))); // R2
endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wd_load,
  input  logic [LANE_W-1:0] wd_in,
  input  logic              cap,
  input  logic              lane_en,
  input  logic [LANE_W-1:0] dq_in,
  output logic [LANE_W-1:0] wd_out,
  output logic [LANE_W-1:0] rd_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_out <= '0;
      rd_out <= '0;
    end else begin
      if (wd_load) wd_out <= wd_in;
      if (cap)     rd_out <= lane_en ? dq_in : '0;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int LANE_W   = 8,
  parameter int CLK_PS   = 10000,
  parameter int T_ACC_PS = 55000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_be,
  output logic                resp_ack,
  output logic [2*LANE_W-1:0] resp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_cs_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic                mem_ub_n,
  output logic                mem_lb_n,
  inout  wire  [2*LANE_W-1:0] mem_dq,
  output logic                mem_dq_oe
);
  localparam int DATA_W = 2 * LANE_W;
  localparam int WAIT   = ceil_div(T_ACC_PS, CLK_PS);

  ctrl_state_e       state_q;
  logic              write_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wd_q;
  logic              acc_last;
  logic              take;
  logic              cap;

  assign take = (state_q == ST_IDLE) && req_valid;
  assign cap  = acc_last && !write_q;

  sram_wait_timer #(.WAIT(WAIT)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_ACC),
    .last (acc_last)
  );

  for (genvar i = 0; i < 2; i++) begin : g_lane
    sram_lane_io #(.LANE_W(LANE_W)) lane_i (
      .clk     (clk),
      .rst     (rst),
      .wd_load (take),
      .wd_in   (req_wdata[i*LANE_W +: LANE_W]),
      .cap     (cap),
      .lane_en (be_q[i]),
      .dq_in   (mem_dq[i*LANE_W +: LANE_W]),
      .wd_out  (wd_q[i*LANE_W +: LANE_W]),
      .rd_out  (resp_rdata[i*LANE_W +: LANE_W])
    );
  end

  assign mem_dq = mem_dq_oe ? wd_q : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      write_q   <= 1'b0;
      be_q      <= '0;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      resp_ack  <= 1'b0;
    end else begin
      resp_ack <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            write_q  <= req_write;
            be_q     <= req_be;
            mem_addr <= req_addr;
            if (req_be == 2'b00) begin
              resp_ack <= 1'b1;
              state_q  <= ST_GAP;
            end else begin
              state_q   <= ST_ACC;
              mem_cs_n  <= 1'b0;
              mem_we_n  <= !req_write;
              mem_oe_n  <= req_write;
              mem_ub_n  <= !req_be[1];
              mem_lb_n  <= !req_be[0];
              mem_dq_oe <= req_write;
            end
          end
        end
        ST_ACC: begin
          if (acc_last) begin
            state_q  <= ST_GAP;
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_ub_n <= 1'b1;
            mem_lb_n <= 1'b1;
            resp_ack <= 1'b1;
          end
        end
        default: begin
          state_q   <= ST_IDLE;
          mem_dq_oe <= 1'b0;
        end
      endcase
    end
  end

  AST_OE_DRIVE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n)); // R8
  AST_DRIVE_AFTER_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> $past(mem_oe_n)); // R8
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n)); // R4
  AST_WE_RISE_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(wd_q))); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_ack |=> !resp_ack); // R5
  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs_n) |=> mem_cs_n); // R7
  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (mem_cs_n && mem_we_n && mem_oe_n)); // R1
endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  localparam int AW   = 6;
  localparam int WAIT = 6;
  localparam int NW   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          resp_ack;
  logic [15:0]   resp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  wire  [15:0]   mem_dq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .resp_ack(resp_ack), .resp_rdata(resp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq(mem_dq),
    .mem_dq_oe(mem_dq_oe)
  );

  // Behavioural memory, one array per byte lane
  logic [7:0] lo_m [NW];
  logic [7:0] hi_m [NW];
  logic       mdl_rd;
  assign mdl_rd = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq[7:0]  = (mdl_rd && !mem_lb_n) ? lo_m[mem_addr] : 8'bz;
  assign mem_dq[15:8] = (mdl_rd && !mem_ub_n) ? hi_m[mem_addr] : 8'bz;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit            wr_prev = 1'b0;
  logic [AW-1:0] p_a;
  logic [15:0]   p_d;
  logic          p_lb, p_ub;
  int            cs_run = 0;
  int            hi_run = 0;
  int            n_acc  = 0;
  int            n_clash = 0;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) begin
        lo_m[i] = 8'h00;
        hi_m[i] = 8'h00;
      end
      wr_prev = 1'b0;
    end else begin
      if (wr_prev && mem_we_n) begin
        if (!p_lb) lo_m[p_a] = p_d[7:0];
        if (!p_ub) hi_m[p_a] = p_d[15:8];
      end
      wr_prev = !mem_cs_n && !mem_we_n;
      p_a = mem_addr; p_d = mem_dq; p_lb = mem_lb_n; p_ub = mem_ub_n;
      if ((mem_dq_oe && mdl_rd) || (mem_dq_oe && !mem_oe_n)) n_clash++;
      if (!mem_cs_n) begin
        if (cs_run == 0) check(hi_run >= 1, "R7 idle before access", hi_run, 1);
        cs_run++;
        hi_run = 0;
      end else begin
        hi_run++;
        if (cs_run != 0) begin
          check(cs_run == WAIT, "R2 chip-select width", cs_run, WAIT);
          n_acc++;
          cs_run = 0;
        end
      end
    end
  end

  task automatic access(input bit wr, input int a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] rd);
    int n;
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!resp_ack && n < 50);
    check(resp_ack, "R5 acknowledge arrives", int'(resp_ack), 1);
    rd = resp_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    check(!resp_ack, "R5 acknowledge single cycle", int'(resp_ack), 0);
  endtask

  function automatic logic [15:0] w0(input int a);
    return 16'(a * 16'h0103 + 16'h1111);
  endfunction

  function automatic logic [15:0] exp_word(input int a);
    logic [15:0] e;
    e = w0(a);
    if (a % 2 == 1) e[7:0]  = ~e[7:0];
    else            e[15:8] = ~e[15:8];
    return e;
  endfunction

  initial begin
    logic [15:0] rd;
    int acc0;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !resp_ack,
          "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, resp_ack}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 idle after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

    // R3: full-word writes everywhere, then R4 full read-back
    for (int a = 0; a < NW; a++) access(1'b1, a, w0(a), 2'b11, rd);
    for (int a = 0; a < NW; a++) begin
      access(1'b0, a, 16'h0, 2'b11, rd);
      check(rd == w0(a), "R4 full read-back", rd, w0(a));
    end

    // R3: single-lane writes (odd address -> low lane, even -> high lane)
    for (int a = 0; a < NW; a++)
      access(1'b1, a, ~w0(a), (a % 2 == 1) ? 2'b01 : 2'b10, rd);
    for (int a = 0; a < NW; a++) begin
      access(1'b0, a, 16'h0, 2'b11, rd);
      check(rd == exp_word(a), "R3 lane-masked write", rd, exp_word(a));
    end

    // R4: single-lane reads return zero in the disabled lane
    for (int a = 0; a < NW; a++) begin
      access(1'b0, a, 16'h0, 2'b01, rd);
      check(rd == {8'h00, exp_word(a)[7:0]}, "R4 low-lane read", rd, {8'h00, exp_word(a)[7:0]});
      access(1'b0, a, 16'h0, 2'b10, rd);
      check(rd == {exp_word(a)[15:8], 8'h00}, "R4 high-lane read", rd, {exp_word(a)[15:8], 8'h00});
    end

    // R6: no strobes -> no memory cycle, contents intact
    acc0 = n_acc;
    access(1'b1, 0, 16'hFFFF, 2'b00, rd);
    access(1'b0, 5, 16'h0, 2'b00, rd);
    check(n_acc == acc0, "R6 no chip-select cycle", n_acc - acc0, 0);
    access(1'b0, 0, 16'h0, 2'b11, rd);
    check(rd == exp_word(0), "R6 memory unchanged", rd, exp_word(0));

    repeat (2) @(negedge clk);
    check(n_clash == 0, "R8 bus drive overlap cycles", n_clash, 0);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 idle at end", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule